// File: doc/BRIEF.md
# Two-Stage Subranging Result Merger

This block sits behind the two quantizers of a subranging analog-to-digital converter and turns their separate results into one output word. The first quantizer gives a 3-bit coarse code. The second quantizer works on the amplified residue and gives a 4-bit fine code. The fine code has one bit more than it strictly needs, so the residue can stray above the nominal fine range without losing information. The top bit of the fine code says whether the coarse decision was one step too low. The block then adds that bit to the coarse code and appends the three low fine bits, which gives a 6-bit result.

The stages are pipelined, so the fine code of a sample arrives after its coarse code. Coarse codes are held in a small first-in-first-out queue until the matching fine code is strobed. If a coarse code of all ones would be incremented past its range, the output clamps to all ones and an overrange flag is raised. Every output is registered.

Top module: `subrange_merge`

## Requirements
- R1: While reset is high, and on the first clock after it, out_vld, out_code and out_ovr are all 0.
- R2: out_vld is high for exactly one cycle, the cycle after a clock edge where fin_vld is high and at least one coarse code is waiting. It is low in every other cycle.
- R3: If the fine code's top bit (bit 3) is 0, out_code is {coarse, fine[2:0]} and out_ovr is 0.
- R4: If fine bit 3 is 1 and the coarse code is below 7, out_code is {coarse+1, fine[2:0]} and out_ovr is 0.
- R5: If fine bit 3 is 1 and the coarse code is 7, out_code is 63 (all ones) and out_ovr is 1.
- R6: Coarse codes pair with fine codes in arrival order, oldest first. If a coarse code and a fine code are strobed in the same cycle, the fine code pairs with the oldest coarse code already waiting, never with the new one.
- R7: A fine code strobed while no coarse code is waiting is ignored. It gives no output and does not change out_code or out_ovr.
- R8: The queue holds up to QDEPTH (default 4) coarse codes. A coarse code strobed while the queue is full, in a cycle with no fine strobe, is discarded. Later fine codes pair with the codes that were kept.
- R9: While out_vld is low, out_code and out_ovr keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| crs_vld | input | 1 | Strobe: coarse code is present |
| crs_code | input | CRS_W (3) | Coarse quantizer result |
| fin_vld | input | 1 | Strobe: fine code is present |
| fin_code | input | FIN_W (4) | Fine quantizer result; bit 3 is the redundant correction bit |
| out_vld | output | 1 | Merged word is valid this cycle |
| out_code | output | CRS_W+FIN_W-1 (6) | Corrected output word |
| out_ovr | output | 1 | Correction would overflow; out_code is clamped to all ones |

## Verification
The bench sends pairs whose fine top bit is clear, pairs where it is set with a coarse code below 7, and pairs where it is set with coarse 7. These three cases separate a plain join of the two codes, a correct increment and the clamp. Coarse 7 paired with a clear top bit checks that the clamp and flag do not depend on the coarse value alone.

Other patterns check the pairing logic. A coarse and a fine code strobed in the same cycle, a run of several coarse codes before their fine codes, an orphan fine strobe and an overfilled queue each show whether pairing stays in order. A long pseudo-random strobe sequence then mixes all of these cases against a reference queue model.

// File: rtl/srm_pkg.sv
package srm_pkg;
  localparam int SRM_CRS_W  = 3;
  localparam int SRM_FIN_W  = 4;
  localparam int SRM_QDEPTH = 4;

  // Width of the merged word: the fine stage overlaps the coarse LSB by one bit
  function automatic int merged_width(input int crs_w, input int fin_w);
    return crs_w + fin_w - 1;
  endfunction
endpackage

// File: rtl/srm_coarse_queue.sv
module srm_coarse_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_pop, do_push;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Storage has no reset so it maps onto plain memory
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/srm_corrector.sv
module srm_corrector #(
  parameter int CRS_W = 3,
  parameter int FIN_W = 4,
  parameter int OUT_W = CRS_W + FIN_W - 1
) (
  input  logic [CRS_W-1:0] crs,
  input  logic [FIN_W-1:0] fin,
  output logic [OUT_W-1:0] code,
  output logic             ovr
);
  logic [CRS_W:0] sum;

  always_comb begin
    sum  = {1'b0, crs} + {{CRS_W{1'b0}}, fin[FIN_W-1]};
    ovr  = sum[CRS_W];
    code = ovr ? {OUT_W{1'b1}} : {sum[CRS_W-1:0], fin[FIN_W-2:0]};
  end
endmodule

// File: rtl/subrange_merge.sv
module subrange_merge
  import srm_pkg::*;
#(
  parameter int CRS_W  = SRM_CRS_W,
  parameter int FIN_W  = SRM_FIN_W,
  parameter int QDEPTH = SRM_QDEPTH,
  parameter int OUT_W  = merged_width(CRS_W, FIN_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             crs_vld,
  input  logic [CRS_W-1:0] crs_code,
  input  logic             fin_vld,
  input  logic [FIN_W-1:0] fin_code,
  output logic             out_vld,
  output logic [OUT_W-1:0] out_code,
  output logic             out_ovr
);
  logic [CRS_W-1:0] head;
  logic             q_empty, q_full;
  logic             pair;
  logic [OUT_W-1:0] fix_code;
  logic             fix_ovr;

  assign pair = fin_vld && !q_empty;

  srm_coarse_queue #(.DEPTH(QDEPTH), .W(CRS_W)) u_queue (
    .clk   (clk),
    .rst   (rst),
    .push  (crs_vld),
    .din   (crs_code),
    .pop   (fin_vld),
    .dout  (head),
    .empty (q_empty),
    .full  (q_full)
  );

  srm_corrector #(.CRS_W(CRS_W), .FIN_W(FIN_W), .OUT_W(OUT_W)) u_fix (
    .crs  (head),
    .fin  (fin_code),
    .code (fix_code),
    .ovr  (fix_ovr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_code <= '0;
      out_ovr  <= 1'b0;
    end else begin
      out_vld <= pair;
      if (pair) begin
        out_code <= fix_code;
        out_ovr  <= fix_ovr;
      end
    end
  end
endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
  parameter int FIN_W = 4,
  parameter int OUT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             fin_vld,
  input logic [FIN_W-1:0] fin_code,
  input logic             out_vld,
  input logic [OUT_W-1:0] out_code,
  input logic             out_ovr
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_vld && out_code == '0 && !out_ovr));

  a_r2_vld_follows_fine: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(fin_vld));

  a_r3_low_bits_kept: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_ovr) |-> out_code[FIN_W-2:0] == $past(fin_code[FIN_W-2:0]));

  a_r3_no_flag_when_clear: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !$past(fin_code[FIN_W-1])) |-> !out_ovr);

  a_r5_clamp_all_ones: assert property (@(posedge clk) disable iff (rst)
    out_ovr |-> out_code == {OUT_W{1'b1}});

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> ($stable(out_code) && $stable(out_ovr)));
endmodule

bind subrange_merge srm_checker #(.FIN_W(FIN_W), .OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fin_vld  (fin_vld),
  .fin_code (fin_code),
  .out_vld  (out_vld),
  .out_code (out_code),
  .out_ovr  (out_ovr)
);

// File: tb/test_subrange_merge.sv
module test_subrange_merge;
  localparam int CW = 3, FW = 4, QD = 4, OW = CW + FW - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic crs_vld = 1'b0, fin_vld = 1'b0;
  logic [CW-1:0] crs_code = '0;
  logic [FW-1:0] fin_code = '0;
  logic out_vld, out_ovr;
  logic [OW-1:0] out_code;

  always #5 clk = ~clk;

  subrange_merge #(.CRS_W(CW), .FIN_W(FW), .QDEPTH(QD)) i_subrange_merge (
    .clk(clk), .rst(rst), .crs_vld(crs_vld), .crs_code(crs_code),
    .fin_vld(fin_vld), .fin_code(fin_code),
    .out_vld(out_vld), .out_code(out_code), .out_ovr(out_ovr)
  );

  typedef struct {
    logic          vld;
    logic [OW-1:0] code;
    logic          ovr;
    string         tag;
  } exp_t;

  exp_t          exp_q[$];
  int            crs_q[$];
  logic [OW-1:0] last_code = '0;
  logic          last_ovr  = 1'b0;
  int            errors = 0, checks = 0;
  bit            done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // Driver: applies one cycle of stimulus and records the expected outcome
  task automatic drive(input bit cv, input int cc, input bit fv, input int fc,
                       input string note);
    exp_t e;
    int   sz;
    bit   pp;
    int   sum;
    @(negedge clk);
    crs_vld = cv; crs_code = CW'(cc); fin_vld = fv; fin_code = FW'(fc);
    sz = crs_q.size();
    pp = fv && (sz > 0);
    e.vld = pp;
    if (pp) begin
      sum = crs_q.pop_front() + ((fc >> 3) & 1);
      if (sum > 7) begin
        e.code = '1; e.ovr = 1'b1; e.tag = "R5";
      end else begin
        e.code = OW'(sum * 8 + (fc & 7)); e.ovr = 1'b0;
        e.tag = ((fc >> 3) & 1) ? "R4" : "R3";
      end
      last_code = e.code; last_ovr = e.ovr;
    end else begin
      e.code = last_code; e.ovr = last_ovr; e.tag = "R9";
    end
    if (cv && (sz < QD || pp)) crs_q.push_back(cc);
    if (note != "") e.tag = note;
    exp_q.push_back(e);
  endtask

  // Monitor: compares each cycle's registered outputs with the scoreboard
  always @(posedge clk) begin
    #2;
    if (!rst && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(out_vld == e.vld, {e.tag, "/R2"}, "out_vld", out_vld, e.vld);
      check(out_code == e.code, e.tag, "out_code", out_code, e.code);
      check(out_ovr == e.ovr, e.tag, "out_ovr", out_ovr, e.ovr);
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs clear during reset
    check(out_vld == 0 && out_code == 0 && out_ovr == 0, "R1", "reset outputs",
          {out_vld, out_code, out_ovr}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(out_vld == 0 && out_code == 0 && out_ovr == 0, "R1", "after reset",
          {out_vld, out_code, out_ovr}, 0);

    // R3: fine top bit clear -> plain join
    drive(1, 5, 0, 0, "");
    drive(0, 0, 1, 3, "R3");
    drive(0, 0, 0, 0, "R9");
    // R4: increment coarse
    drive(1, 2, 0, 0, "");
    drive(0, 0, 1, 12, "R4");
    // R5: clamp and flag
    drive(1, 7, 0, 0, "");
    drive(0, 0, 1, 9, "R5");
    drive(0, 0, 0, 0, "R9");
    // coarse 7 with clear top bit: no clamp (R3)
    drive(1, 7, 0, 0, "");
    drive(0, 0, 1, 5, "R3");
    // coarse 6 + carry reaches 63 without the flag (R4)
    drive(1, 6, 0, 0, "");
    drive(0, 0, 1, 15, "R4");
    // R7: orphan fine strobe ignored
    drive(0, 0, 1, 8, "R7");
    drive(0, 0, 0, 0, "R7");
    // R6: simultaneous strobe pairs with the older coarse code
    drive(1, 1, 0, 0, "");
    drive(1, 4, 1, 2, "R6");
    drive(1, 3, 1, 10, "R6");
    drive(0, 0, 1, 6, "R6");
    // R6: empty queue, same-cycle strobes -> fine dropped, coarse kept
    drive(1, 5, 1, 1, "R6");
    drive(0, 0, 1, 1, "R6");
    // R8: overfill queue, fifth coarse dropped
    for (int k = 0; k < 5; k++) drive(1, k + 1, 0, 0, "R8");
    for (int k = 0; k < 5; k++) drive(0, 0, 1, k, "R8");
    drive(0, 0, 0, 0, "R8");
    // Mixed pseudo-random traffic
    for (int k = 0; k < 400; k++)
      drive($urandom % 2, $urandom % 8, $urandom % 2, $urandom % 16, "");
    for (int k = 0; k < 6; k++) drive(0, 0, 1, 0, "");
    drive(0, 0, 0, 0, "");
    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule